// File: doc/BRIEF.md
# Key-Sequence Write-Enable Lock

This block guards the single write-enable flag that a timekeeping register bank uses to accept writes. Software cannot simply set the flag: it must first write the first key value and then the second key value to a dedicated key register, and then set the flag in the clock cycle that directly follows the second key. If the set comes at any other time, the flag does not change.

The flag stays high until software clears it, and clearing needs no key sequence. The block decodes a plain bus write port: a strobe, an address and data. It combines the flag with writes that fall in the timekeeping address range and passes on only the writes that are permitted. A separate read address returns the flag at its bit position in the control register. The protected registers and any interrupt masking during the sequence belong to other blocks.

Top module: `keyed_wen_lock`

## Requirements
- R1: After synchronous reset, `wen` is 0 and the sequencer is idle, so a second-key write followed by a set attempt leaves `wen` at 0.
- R2: A write of 0x55 to the key address, then a write of 0xAA to the key address on a later cycle, then in the very next clock cycle a control-register write with bit 5 = 1, sets `wen` to 1 from the following cycle on.
- R3: The set window lasts exactly one clock cycle after the 0xAA write. A set attempt in any later cycle leaves `wen` at 0.
- R4: A control write with bit 5 = 1 that has no key sequence before it leaves `wen` at 0.
- R5: After 0x55, any bus write other than 0xAA to the key address (another key value, or a write to any other address) returns the sequencer to idle, and a later 0xAA does not open the window.
- R6: The keys in the reverse order (0xAA then 0x55) do not open the window.
- R7: A 0x55 key write in any state, including the open window, restarts the sequence as "first key received".
- R8: A control write with bit 5 = 0 clears `wen` on the next cycle, with or without a key sequence.
- R9: A set attempt outside the window leaves `wen` unchanged (it stays 1 if already 1) and cancels a sequence in progress.
- R10: `tk_wr_grant` is 1 exactly when `wr_en` is 1, `wr_addr` lies in [0x20, 0x27] and `wen` is 1.
- R11: `rd_data` shows `wen` at bit 5 when `rd_addr` is the control address 0x11, and 0 for every other address. Reads and idle cycles between the two keys do not disturb the sequencer. The key address is 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 8 | Bus write data |
| rd_addr | input | 8 | Read address for flag readback |
| rd_data | output | 8 | Readback data |
| wen | output | 1 | Timekeeping write-enable flag |
| tk_wr_grant | output | 1 | Qualified write strobe for the timekeeping bank |

## Verification
The embedded assertions check on every cycle that the flag rises only after an open window and a set request, that a clear always wins, that the window never lasts two cycles and always follows a second-key write, and that a granted timekeeping write never occurs with the flag low. Whether a given ordering of writes should open the window at all cannot be seen from any single cycle. Restarts, the wrong second key, reversed keys, a late set, a cancelled window and reads between the keys are therefore shown by the bench scenarios, which compare against a behavioural model on every clock.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_GOT1  = 2'd1,
        S_ARMED = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic any_wr;
        logic key1_wr;
        logic key2_wr;
        logic ctrl_set;
        logic ctrl_clr;
        logic tk_wr;
    } bus_dec_t;

    function automatic logic in_window(input int unsigned addr,
                                       input int unsigned base,
                                       input int unsigned count);
        return (addr >= base) && (addr < base + count);
    endfunction

endpackage

// File: rtl/wlock_decode.sv
module wlock_decode
    import wlock_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int KEY_ADDR  = 'h10,
    parameter int CTRL_ADDR = 'h11,
    parameter int WEN_BIT   = 5,
    parameter int KEY1      = 'h55,
    parameter int KEY2      = 'hAA,
    parameter int TK_BASE   = 'h20,
    parameter int TK_COUNT  = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output bus_dec_t          dec
);
    localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [DATA_W-1:0] K1     = DATA_W'(KEY1);
    localparam logic [DATA_W-1:0] K2     = DATA_W'(KEY2);

    logic hit_key, hit_ctrl;

    always_comb begin
        hit_key      = wr_en && (wr_addr == KEY_A);
        hit_ctrl     = wr_en && (wr_addr == CTRL_A);
        dec.any_wr   = wr_en;
        dec.key1_wr  = hit_key && (wr_data == K1);
        dec.key2_wr  = hit_key && (wr_data == K2);
        dec.ctrl_set = hit_ctrl && wr_data[WEN_BIT];
        dec.ctrl_clr = hit_ctrl && !wr_data[WEN_BIT];
        dec.tk_wr    = wr_en && in_window(int'(wr_addr), TK_BASE, TK_COUNT);
    end
endmodule

// File: rtl/wlock_seq.sv
module wlock_seq
    import wlock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_dec_t dec_i,
    output logic     win_o
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (dec_i.any_wr) begin
            if (dec_i.key1_wr)
                state_d = S_GOT1;
            else if (dec_i.key2_wr && state_q == S_GOT1)
                state_d = S_ARMED;
            else
                state_d = S_IDLE;
        end else if (state_q == S_ARMED) begin
            state_d = S_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign win_o = (state_q == S_ARMED);

    // R3
    win_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_ARMED) |=> (state_q != S_ARMED));

    // R5
    win_after_key2_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(win_o) |-> $past(dec_i.key2_wr));
endmodule

// File: rtl/wlock_bit.sv
module wlock_bit
    import wlock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_dec_t dec_i,
    input  logic     win_i,
    output logic     wen_o
);
    always_ff @(posedge clk) begin
        if (rst)
            wen_o <= 1'b0;
        else if (dec_i.ctrl_clr)
            wen_o <= 1'b0;
        else if (dec_i.ctrl_set && win_i)
            wen_o <= 1'b1;
    end

    // R2
    wen_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wen_o) |-> $past(win_i && dec_i.ctrl_set));

    // R8
    wen_clear_chk: assert property (@(posedge clk) disable iff (rst)
        dec_i.ctrl_clr |=> !wen_o);

    // R1
    wen_reset_chk: assert property (@(posedge clk)
        rst |=> !wen_o);
endmodule

// File: rtl/keyed_wen_lock.sv
module keyed_wen_lock
    import wlock_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int KEY_ADDR  = 'h10,
    parameter int CTRL_ADDR = 'h11,
    parameter int WEN_BIT   = 5,
    parameter int KEY1      = 'h55,
    parameter int KEY2      = 'hAA,
    parameter int TK_BASE   = 'h20,
    parameter int TK_COUNT  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wen,
    output logic              tk_wr_grant
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    bus_dec_t dec;
    logic     win;

    wlock_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
        .CTRL_ADDR(CTRL_ADDR), .WEN_BIT(WEN_BIT), .KEY1(KEY1),
        .KEY2(KEY2), .TK_BASE(TK_BASE), .TK_COUNT(TK_COUNT)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .dec(dec)
    );

    wlock_seq u_seq (
        .clk(clk), .rst(rst), .dec_i(dec), .win_o(win)
    );

    wlock_bit u_bit (
        .clk(clk), .rst(rst), .dec_i(dec), .win_i(win), .wen_o(wen)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_A) rd_data[WEN_BIT] = wen;
    end

    assign tk_wr_grant = dec.tk_wr && wen;

    // R10
    grant_needs_wen_chk: assert property (@(posedge clk) disable iff (rst)
        tk_wr_grant |-> wen);
endmodule

// File: tb/keyed_wen_lock_bench.sv
module keyed_wen_lock_bench;
    localparam logic [7:0] KA = 8'h10, CA = 8'h11, TA = 8'h23;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic       wen, tk_wr_grant;

    int n_run = 0, n_fail = 0, cyc = 0;
    int m_stage = 0;
    bit m_wen = 0;

    always #2.5 clk = ~clk;

    keyed_wen_lock u_keyed_wen_lock (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wen(wen), .tk_wr_grant(tk_wr_grant)
    );

    // behavioural reference: stage 0 idle, 1 first key seen, 2 window open
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_stage = 0; m_wen = 0;
        end else if (wr_en) begin
            if (wr_addr == CA) begin
                if (wr_data[5]) begin
                    if (m_stage == 2) m_wen = 1;
                end else m_wen = 0;
            end
            if (wr_addr == KA && wr_data == 8'h55) m_stage = 1;
            else if (wr_addr == KA && wr_data == 8'hAA && m_stage == 1) m_stage = 2;
            else m_stage = 0;
        end else if (m_stage == 2) m_stage = 0;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] ra);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; rd_addr = ra;
        #1;
        if (!rst) begin
            chk("R2 model wen", int'(wen), int'(m_wen));
            chk("R10 model grant", int'(tk_wr_grant),
                int'(w && a >= 8'h20 && a <= 8'h27 && m_wen));
            chk("R11 model readback", int'(rd_data),
                (ra == CA) ? (int'(m_wen) << 5) : 0);
        end
    endtask

    task automatic idle(); step(0, 8'h00, 8'h00, CA); endtask
    task automatic wk(input logic [7:0] d); step(1, KA, d, CA); endtask
    task automatic wset(); step(1, CA, 8'h20, CA); endtask
    task automatic wclr(); step(1, CA, 8'h00, CA); endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        chk("R1 reset wen", int'(wen), 0);
        chk("R1 reset readback", int'(rd_data), 0);
        wk(8'hAA); wset(); idle();
        chk("R1 idle after reset", int'(wen), 0);

        wset(); idle();
        chk("R4 set without keys", int'(wen), 0);

        wk(8'h55); wk(8'hAA); wset(); idle();
        chk("R2 unlock sequence", int'(wen), 1);
        chk("R11 readback set", int'(rd_data), 8'h20);
        step(1, TA, 8'h12, 8'h00);
        chk("R10 grant with wen", int'(tk_wr_grant), 1);
        chk("R11 other address reads zero", int'(rd_data), 0);

        wset(); idle();
        chk("R9 set outside window keeps 1", int'(wen), 1);

        wclr(); idle();
        chk("R8 clear without keys", int'(wen), 0);
        step(1, TA, 8'h12, CA);
        chk("R10 grant blocked", int'(tk_wr_grant), 0);

        wk(8'h55); wk(8'hAA); idle(); wset(); idle();
        chk("R3 late set", int'(wen), 0);

        wk(8'h55); wk(8'h33); wk(8'hAA); wset(); idle();
        chk("R5 wrong second key", int'(wen), 0);
        wk(8'h55); step(1, 8'h40, 8'hAA, CA); wk(8'hAA); wset(); idle();
        chk("R5 foreign write between keys", int'(wen), 0);

        wk(8'hAA); wk(8'h55); wset(); idle();
        chk("R6 reversed keys", int'(wen), 0);

        wk(8'h55); wk(8'h55); wk(8'hAA); wset(); idle();
        chk("R7 repeated first key", int'(wen), 1);
        wclr(); idle();
        wk(8'h55); wk(8'hAA); wk(8'h55); wk(8'hAA); wset(); idle();
        chk("R7 restart during window", int'(wen), 1);
        wclr(); idle();

        wk(8'h55); wset(); wk(8'hAA); wset(); idle();
        chk("R9 set cancels sequence", int'(wen), 0);

        wk(8'h55);
        for (int i = 0; i < 5; i++) step(0, 8'h00, 8'h00, 8'(8'h10 + i));
        wk(8'hAA); wset(); idle();
        chk("R11 reads between keys", int'(wen), 1);
        wclr(); idle();
        chk("R8 clear after unlock", int'(wen), 0);

        repeat (4) idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 5000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule